// File: doc/BRIEF.md
# Mode-Switchable Receive Character Queue

This block holds received characters for a 16550-style serial controller until the register interface reads them. It runs in one of two modes. In legacy mode it stores a single character. In queued mode it stores up to sixteen. The line side, or the loopback path, offers one byte per cycle with a valid strobe. The register side takes the oldest byte with a pop strobe, and the head byte is always visible on an output.

Software picks the mode with an enable level. Any change of that level empties the queue and sets the new capacity. A separate flush pulse empties the queue while queued mode is active, and has no effect in legacy mode. A byte offered while the queue holds as many characters as the current capacity is refused, and an overrun pulse reports it. The full flag lets the line side hold off. If a byte is offered and the head is popped in the same cycle on a full queue, the pop happens first, so the byte is accepted.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the queue is empty, its capacity is one, `head_data` reads 0xFF, and `full` and `overrun` are low.
- R2: In legacy mode (`fifo_en` low) the queue holds at most one byte. A second push without a pop is refused.
- R3: In queued mode (`fifo_en` high) the queue holds up to sixteen bytes and returns them in arrival order.
- R4: In a cycle where `fifo_en` differs from the current mode, the queue is emptied, the mode takes the new level, and any push or pop in that cycle is ignored.
- R5: A `rx_flush` pulse in queued mode empties the queue and keeps capacity at sixteen. In legacy mode `rx_flush` has no effect.
- R6: A push while occupancy equals capacity, with no pop in the same cycle, is refused. The contents stay unchanged, and `overrun` is high for exactly the next cycle.
- R7: While the queue is empty, `head_data` is 0xFF, and a pop changes nothing.
- R8: Read and write positions wrap at the current capacity, so the arrival order is preserved across any number of wraps.
- R9: A push and a pop in the same cycle on a full queue are both accepted. Occupancy stays at capacity and no overrun is reported.
- R10: `full` is high exactly when occupancy equals the current capacity. `not_empty` is high exactly when occupancy is nonzero. `count` is the occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Offer `push_data` to the queue this cycle |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Remove the head byte this cycle |
| fifo_en | input | 1 | Mode level: 0 = single byte, 1 = sixteen bytes |
| rx_flush | input | 1 | Empty the queue (queued mode only) |
| head_data | output | 8 | Oldest byte, or 0xFF when empty |
| count | output | 5 | Occupancy |
| not_empty | output | 1 | Occupancy is nonzero |
| full | output | 1 | Occupancy equals capacity |
| overrun | output | 1 | One-cycle pulse after a refused push |

## Verification
A wrong pointer or occupancy value appears on `head_data` at the next pop as a byte out of order, repeated or missing. A stale capacity appears one cycle after the offending push, as a `full` flag at the wrong depth or as a missing or spurious `overrun` pulse. A flush that is missed leaves `not_empty` high on the cycle right after the mode change or flush pulse. For these reasons the bench checks every port after every cycle against a queue model, so a divergence is caught in the cycle it first appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Capacity in effect for a given mode.
  function automatic int unsigned cap_of(input logic big, input int unsigned deep);
    return big ? deep : 1;
  endfunction

  // Advance a position, wrapping at the effective capacity.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned cap);
    return (p + 1 >= cap) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEEP  = 16,
  parameter int PTR_W = $clog2(DEEP),
  parameter int CNT_W = $clog2(DEEP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             pop,
  input  logic             fifo_en,
  input  logic             rx_flush,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             mode,
  output logic             mode_change,
  output logic             flush_evt,
  output logic             overrun,
  output logic [CNT_W-1:0] cap
);
  logic normal, pop_ok, push_ok, refuse;

  assign mode_change = (fifo_en != mode);
  assign flush_evt   = !mode_change && rx_flush && mode;
  assign normal      = !mode_change && !flush_evt;
  assign cap         = CNT_W'(rxq_pkg::cap_of(mode, DEEP));
  assign pop_ok      = normal && pop && (count != '0);
  assign push_ok     = normal && push_valid && ((count < cap) || pop_ok);
  assign refuse      = normal && push_valid && !push_ok;
  assign wr_en       = push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= refuse;
      mode    <= fifo_en;
      if (!normal) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_ok) wr_ptr <= PTR_W'(rxq_pkg::wrap_inc(32'(wr_ptr), 32'(cap)));
        if (pop_ok)  rd_ptr <= PTR_W'(rxq_pkg::wrap_inc(32'(rd_ptr), 32'(cap)));
        case ({push_ok, pop_ok})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEEP   = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEEP)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEEP];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEEP   = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEEP),
  localparam int CNT_W = $clog2(DEEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              fifo_en,
  input  logic              rx_flush,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              not_empty,
  output logic              full,
  output logic              overrun
);
  logic             wr_en, mode, mode_change, flush_evt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cap;
  logic [DATA_W-1:0] rd_data;

  rxq_ctrl #(.DEEP(DEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
    .fifo_en(fifo_en), .rx_flush(rx_flush), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count), .mode(mode),
    .mode_change(mode_change), .flush_evt(flush_evt),
    .overrun(overrun), .cap(cap)
  );

  rxq_store #(.DEEP(DEEP), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(push_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  assign not_empty = (count != '0);
  assign full      = (count == cap);
  assign head_data = not_empty ? rd_data : '1;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              pop,
  input logic              mode,
  input logic              mode_change,
  input logic              flush_evt,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cap,
  input logic              full,
  input logic              not_empty,
  input logic              overrun,
  input logic [DATA_W-1:0] head_data
);
  AST_LEGACY_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> count <= 1); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap); // R3
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> count == 0); // R4
  AST_RXRST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (count == 0 && mode)); // R5
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop && !mode_change && !flush_evt) |=> (overrun && $stable(count))); // R6
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> head_data == '1); // R7
  AST_SWAP_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop && full && !mode_change && !flush_evt) |=> (!overrun && full)); // R9
  AST_FULL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> not_empty); // R10
endmodule

bind rx_char_queue rxq_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rxq_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
  .mode(mode), .mode_change(mode_change), .flush_evt(flush_evt),
  .count(count), .cap(cap), .full(full), .not_empty(not_empty),
  .overrun(overrun), .head_data(head_data)
);

// File: tb/test_rx_char_queue.sv
module test_rx_char_queue;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       pop = 1'b0;
  logic       fifo_en = 1'b0;
  logic       rx_flush = 1'b0;
  logic [7:0] head_data;
  logic [4:0] count;
  logic       not_empty, full, overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] exp_q[$];
  bit         m_big = 1'b0;
  bit         m_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_queue i_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop(pop), .fifo_en(fifo_en), .rx_flush(rx_flush), .head_data(head_data),
    .count(count), .not_empty(not_empty), .full(full), .overrun(overrun)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every port with the model
  task automatic compare_all(input string tag);
    int cap = m_big ? 16 : 1;
    chk(tag, "count", count, exp_q.size());
    chk(tag, "not_empty", not_empty, exp_q.size() != 0);
    chk("R10", "full", full, exp_q.size() == cap);
    chk(tag, "overrun", overrun, m_ovr);
    chk(tag, "head_data", head_data, exp_q.size() != 0 ? exp_q[0] : 8'hFF);
  endtask

  // driver: apply one cycle of stimulus and update the model
  task automatic step(input string tag, input bit pv, input logic [7:0] pd,
                      input bit pp, input bit en, input bit fl);
    int cap = m_big ? 16 : 1;
    bit pop_ok, push_ok;
    @(negedge clk);
    push_valid = pv; push_data = pd; pop = pp; fifo_en = en; rx_flush = fl;
    if (en != m_big) begin
      exp_q.delete(); m_big = en; m_ovr = 1'b0;
    end else if (fl && m_big) begin
      exp_q.delete(); m_ovr = 1'b0;
    end else begin
      pop_ok  = pp && exp_q.size() > 0;
      push_ok = pv && (exp_q.size() < cap || pop_ok);
      if (pop_ok) void'(exp_q.pop_front());
      if (push_ok) exp_q.push_back(pd);
      m_ovr = pv && !push_ok;
    end
    @(posedge clk);
    #1;
    push_valid = 1'b0; pop = 1'b0; rx_flush = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R1 reset state
    compare_all("R1");
    chk("R1", "head reset", head_data, 8'hFF);

    // R2 legacy mode: one byte, second refused
    step("R2", 1, 8'hA1, 0, 0, 0);
    step("R6", 1, 8'hB2, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 0, 0);         // overrun gone after one cycle
    step("R2", 0, 8'h00, 1, 0, 0);
    step("R7", 0, 8'h00, 1, 0, 0);          // pop while empty
    step("R9", 1, 8'hC3, 0, 0, 0);
    step("R9", 1, 8'hC4, 1, 0, 0);          // swap on full legacy
    step("R5", 0, 8'h00, 0, 0, 1);          // flush ignored in legacy
    chk("R5", "legacy flush kept", count, 1);

    // R4 switch to queued mode with push and pop present
    step("R4", 1, 8'hEE, 1, 1, 0);
    chk("R4", "flushed on enable", count, 0);

    // R3 fill sixteen
    for (int i = 0; i < 16; i++) step("R3", 1, 8'(8'h10 + i), 0, 1, 0);
    step("R6", 1, 8'h99, 0, 1, 0);
    step("R9", 1, 8'h20, 1, 1, 0);
    // R8 drain half, refill across wrap, drain all
    for (int i = 0; i < 8; i++) step("R8", 0, 8'h00, 1, 1, 0);
    for (int i = 0; i < 8; i++) step("R8", 1, 8'(8'h30 + i), 0, 1, 0);
    for (int i = 0; i < 17; i++) step("R8", 0, 8'h00, 1, 1, 0);
    chk("R7", "empty after drain", head_data, 8'hFF);

    // R5 receiver flush in queued mode
    for (int i = 0; i < 3; i++) step("R5", 1, 8'(8'h50 + i), 0, 1, 0);
    step("R5", 1, 8'h60, 1, 1, 1);
    for (int i = 0; i < 16; i++) step("R5", 1, 8'(8'h70 + i), 0, 1, 0);
    chk("R5", "capacity still 16", full, 1);

    // R4 switch back to legacy drops contents, capacity one
    step("R4", 0, 8'h00, 0, 0, 0);
    step("R4", 1, 8'h81, 0, 0, 0);
    step("R4", 1, 8'h82, 0, 0, 0);
    step("R7", 0, 8'h00, 1, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule